// File: doc/BRIEF.md
# Bus Region Decoder with Byte/Word Width Adaptation

This block sits between a 16-bit processor data bus and a set of memory-mapped targets. For every request it classifies the 16-bit byte address into one of five regions: a small byte-only control-register area, a byte-wide peripheral area, a word-wide peripheral area, RAM, and a non-volatile code/data area at the top of the address space. It drives a one-hot region select, the byte lane enables and the lane-aligned write data to the targets. It also steers the word returned by the selected target back to the processor as a byte or a word.

Decoding of address and access size is purely combinational. Its results are registered once toward the targets. Read data is registered once more on the way back. A read therefore completes two cycles after it is requested. Illegal requests are blocked before they reach any target and are flagged. Legal accesses that land in the top 16 words of memory, where the interrupt vectors sit, are flagged together with the vector's index. The RAM size and the non-volatile base address are parameters.

Top module: `busmap_decoder`

## Requirements
- R1: While `rst` is high, and after it is released with no request, every output is zero.
- R2: One cycle after a legal request, exactly one `sel` bit is high. Bit 0 covers 0x0000-0x000F, bit 1 covers 0x0010-0x00FF, bit 2 covers 0x0100-0x01FF, bit 3 covers 0x0200 up to 0x0200+RAM_BYTES-1, and bit 4 covers NVM_BASE-0xFFFF. With no request or an illegal request, `sel` is zero.
- R3: `tgt_be` bit 0 is the even (low) byte lane and bit 1 is the odd (high) lane. A byte access enables the lane given by address bit 0. A word access enables both lanes, except a word access to the byte-wide peripheral area, which enables only the low lane.
- R4: `tgt_we` or `tgt_re` pulses one cycle after a legal write or read. A byte write places its data byte on both lanes of `tgt_wdata`. A word write passes the word unchanged. `tgt_addr` carries the request's byte address.
- R5: `acc_err` pulses one cycle after an illegal request, with no select, strobe or lane enable. A request is illegal when it is any of: a word access at an odd address, a word access to the control-register area, a byte access at an odd address of the word-wide peripheral area, an address outside all regions, or read and write strobes asserted together.
- R6: Two cycles after any request with `req_rd` high, `cpu_rvalid` pulses for one cycle. A legal byte read returns 0x00 in the high byte and the addressed byte in the low byte. A legal word read returns the word with the even address in bits 7:0.
- R7: A word read from the byte-wide peripheral area returns 0x00 in bits 15:8.
- R8: A word write to the byte-wide peripheral area changes only the even byte. The odd byte keeps its previous value, which a later byte read of the odd address shows.
- R9: A byte read at an even address of the word-wide peripheral area returns 0x00 in bits 15:8.
- R10: An illegal read returns 0x0000 on `cpu_rdata` with `cpu_rvalid` high.
- R11: One cycle after a legal access to 0xFFE0-0xFFFF, `vec_hit` is high and `vec_idx` equals address bits 4:1, so 0xFFFE gives 15. Otherwise both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | 16 | Byte address of the request |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| sel | output | 5 | One-hot region select |
| tgt_addr | output | 16 | Byte address toward the targets |
| tgt_be | output | 2 | Byte lane enables |
| tgt_we | output | 1 | Target write strobe |
| tgt_re | output | 1 | Target read strobe |
| tgt_wdata | output | 16 | Lane-aligned write data |
| tgt_rdata | input | 16 | Word returned by the selected target |
| cpu_rdata | output | 16 | Steered read data |
| cpu_rvalid | output | 1 | Read data valid |
| acc_err | output | 1 | Illegal access flag |
| vec_hit | output | 1 | Access fell in the vector window |
| vec_idx | output | 4 | Vector word index within the window |

## Verification
If a stage-1 register holds a stale or wrong region, size or legality bit, the fault appears on the cycle after the request. It shows as a wrong or double select, a lane enabled on the wrong half, a write strobe reaching a target for an illegal request, or a missing error pulse. A fault in the steering stage appears one cycle later, on `cpu_rdata`. Examples are a nonzero high byte from a byte-wide peripheral, a byte taken from the wrong lane, or leftover data on an error. A wrong lane enable also corrupts the target storage. That corruption shows up on a later read of the untouched byte.

// File: rtl/busmap_pkg.sv
package busmap_pkg;

  localparam int DATA_W      = 16;
  localparam int LANES       = DATA_W / 8;
  localparam int NUM_REGIONS = 5;

  // Fixed low-memory boundaries (exclusive upper limits)
  localparam int CTRL_LIMIT = 'h0010;
  localparam int BP_LIMIT   = 'h0100;
  localparam int WP_LIMIT   = 'h0200;
  localparam int RAM_BASE   = 'h0200;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_CTRL = 3'd1,
    RG_BPER = 3'd2,
    RG_WPER = 3'd3,
    RG_RAM  = 3'd4,
    RG_NVM  = 3'd5
  } region_e;

endpackage

// File: rtl/busmap_region_dec.sv
module busmap_region_dec
  import busmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RAM_BYTES = 2048,
  parameter int NVM_BASE  = 'hC000,
  parameter int VEC_WORDS = 16,
  localparam int IDX_W    = $clog2(VEC_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_acc,
  input  logic              rd,
  input  logic              wr,
  output region_e           region,
  output logic              err,
  output logic              ok,
  output logic [LANES-1:0]  be,
  output logic              vec_hit,
  output logic [IDX_W-1:0]  vec_idx
);

  localparam logic [ADDR_W:0] CTRL_LIM = (ADDR_W+1)'(CTRL_LIMIT);
  localparam logic [ADDR_W:0] BP_LIM   = (ADDR_W+1)'(BP_LIMIT);
  localparam logic [ADDR_W:0] WP_LIM   = (ADDR_W+1)'(WP_LIMIT);
  localparam logic [ADDR_W:0] RAM_LIM  = (ADDR_W+1)'(RAM_BASE + RAM_BYTES);
  localparam logic [ADDR_W:0] NVM_LO   = (ADDR_W+1)'(NVM_BASE);
  localparam logic [ADDR_W:0] VEC_LO   = (ADDR_W+1)'((1 << ADDR_W) - 2 * VEC_WORDS);

  logic [ADDR_W:0] ax;
  logic            active;
  logic            odd;

  assign ax     = {1'b0, addr};
  assign active = rd | wr;
  assign odd    = addr[0];

  always_comb begin
    if (ax < CTRL_LIM)      region = RG_CTRL;
    else if (ax < BP_LIM)   region = RG_BPER;
    else if (ax < WP_LIM)   region = RG_WPER;
    else if (ax < RAM_LIM)  region = RG_RAM;
    else if (ax >= NVM_LO)  region = RG_NVM;
    else                    region = RG_NONE;
  end

  always_comb begin
    err = 1'b0;
    if (active) begin
      if (rd && wr)                           err = 1'b1;
      if (region == RG_NONE)                  err = 1'b1;
      if (!byte_acc && odd)                   err = 1'b1;
      if (!byte_acc && region == RG_CTRL)     err = 1'b1;
      if (byte_acc && odd && region == RG_WPER) err = 1'b1;
    end
  end

  assign ok = active && !err;

  always_comb begin
    be = '0;
    if (ok) begin
      if (byte_acc)              be = odd ? 2'b10 : 2'b01;
      else if (region == RG_BPER) be = 2'b01;
      else                        be = 2'b11;
    end
  end

  assign vec_hit = ok && (ax >= VEC_LO);
  assign vec_idx = vec_hit ? addr[IDX_W:1] : '0;

endmodule

// File: rtl/busmap_lane_ctl.sv
module busmap_lane_ctl
  import busmap_pkg::*;
(
  input  logic              byte_acc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lane_wdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_wdata[8*l +: 8] = byte_acc ? wdata[7:0] : wdata[8*l +: 8];
  end

endmodule

// File: rtl/busmap_rd_steer.sv
module busmap_rd_steer
  import busmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              err,
  input  logic              byte_acc,
  input  logic              odd,
  input  region_e           region,
  input  logic [DATA_W-1:0] tgt_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] steered;

  always_comb begin
    if (err)
      steered = '0;
    else if (byte_acc)
      steered = {8'h00, odd ? tgt_rdata[15:8] : tgt_rdata[7:0]};
    else if (region == RG_BPER)
      steered = {8'h00, tgt_rdata[7:0]};
    else
      steered = tgt_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= capture;
      rdata  <= capture ? steered : '0;
    end
  end

  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (capture && err) |=> (rvalid && rdata == '0)); // R10

  AST_BPER_WORD_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (capture && !err && !byte_acc && region == RG_BPER) |=> (rdata[15:8] == 8'h00)); // R7

endmodule

// File: rtl/busmap_decoder.sv
module busmap_decoder
  import busmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RAM_BYTES = 2048,
  parameter int NVM_BASE  = 'hC000,
  parameter int VEC_WORDS = 16,
  localparam int IDX_W    = $clog2(VEC_WORDS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [15:0]            req_wdata,
  input  logic                   req_byte,
  input  logic                   req_rd,
  input  logic                   req_wr,
  output logic [4:0]             sel,
  output logic [ADDR_W-1:0]      tgt_addr,
  output logic [1:0]             tgt_be,
  output logic                   tgt_we,
  output logic                   tgt_re,
  output logic [15:0]            tgt_wdata,
  input  logic [15:0]            tgt_rdata,
  output logic [15:0]            cpu_rdata,
  output logic                   cpu_rvalid,
  output logic                   acc_err,
  output logic                   vec_hit,
  output logic [IDX_W-1:0]       vec_idx
);

  region_e           d_region;
  logic              d_err, d_ok, d_vec;
  logic [LANES-1:0]  d_be;
  logic [IDX_W-1:0]  d_idx;
  logic [DATA_W-1:0] d_wdata;
  logic [NUM_REGIONS-1:0] d_sel;

  busmap_region_dec #(
    .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES),
    .NVM_BASE(NVM_BASE), .VEC_WORDS(VEC_WORDS)
  ) u_dec (
    .addr(req_addr), .byte_acc(req_byte), .rd(req_rd), .wr(req_wr),
    .region(d_region), .err(d_err), .ok(d_ok), .be(d_be),
    .vec_hit(d_vec), .vec_idx(d_idx)
  );

  busmap_lane_ctl u_lane (
    .byte_acc(req_byte), .wdata(req_wdata), .lane_wdata(d_wdata)
  );

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_sel
    assign d_sel[i] = d_ok && (d_region == region_e'(i + 1));
  end

  // Stage 1: registered decode toward the targets
  region_e q_region;
  logic    q_byte, q_capture;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= '0;
      tgt_addr  <= '0;
      tgt_be    <= '0;
      tgt_we    <= 1'b0;
      tgt_re    <= 1'b0;
      tgt_wdata <= '0;
      acc_err   <= 1'b0;
      vec_hit   <= 1'b0;
      vec_idx   <= '0;
      q_region  <= RG_NONE;
      q_byte    <= 1'b0;
      q_capture <= 1'b0;
    end else begin
      sel       <= d_sel;
      tgt_addr  <= (req_rd | req_wr) ? req_addr : '0;
      tgt_be    <= d_be;
      tgt_we    <= d_ok && req_wr;
      tgt_re    <= d_ok && req_rd;
      tgt_wdata <= (d_ok && req_wr) ? d_wdata : '0;
      acc_err   <= d_err;
      vec_hit   <= d_vec;
      vec_idx   <= d_idx;
      q_region  <= d_region;
      q_byte    <= req_byte;
      q_capture <= req_rd;
    end
  end

  // Stage 2: read steering
  busmap_rd_steer u_steer (
    .clk(clk), .rst(rst), .capture(q_capture), .err(acc_err),
    .byte_acc(q_byte), .odd(tgt_addr[0]), .region(q_region),
    .tgt_rdata(tgt_rdata), .rdata(cpu_rdata), .rvalid(cpu_rvalid)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel)); // R2

  AST_ERR_BLOCKS_TARGET: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> (sel == '0 && !tgt_we && !tgt_re && tgt_be == '0)); // R5

  AST_STROBE_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
    (tgt_we || tgt_re) |-> (tgt_be != '0 && sel != '0)); // R3

  AST_BPER_NO_HIGH_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(sel[1] && tgt_we && tgt_be == 2'b11)); // R8

  AST_VEC_IN_NVM: assert property (@(posedge clk) disable iff (rst)
    vec_hit |-> sel[NUM_REGIONS-1]); // R11

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (tgt_re || (acc_err && q_capture)) |=> cpu_rvalid); // R6

endmodule

// File: tb/busmap_decoder_bench.sv
module busmap_decoder_bench;

  localparam int RAM_BYTES = 2048;
  localparam int NVM_BASE  = 'hC000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_byte = 1'b0, req_rd = 1'b0, req_wr = 1'b0;
  logic [4:0]  sel;
  logic [15:0] tgt_addr, tgt_wdata, cpu_rdata;
  logic [15:0] tgt_rdata = '0;
  logic [1:0]  tgt_be;
  logic        tgt_we, tgt_re, cpu_rvalid, acc_err, vec_hit;
  logic [3:0]  vec_idx;

  int errors = 0;
  int total  = 0;

  always #4 clk = ~clk;

  busmap_decoder #(.RAM_BYTES(RAM_BYTES), .NVM_BASE(NVM_BASE)) u_busmap_decoder (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_byte(req_byte), .req_rd(req_rd), .req_wr(req_wr), .sel(sel),
    .tgt_addr(tgt_addr), .tgt_be(tgt_be), .tgt_we(tgt_we), .tgt_re(tgt_re),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .acc_err(acc_err), .vec_hit(vec_hit), .vec_idx(vec_idx)
  );

  // Target storage model (byte addressed) and the bench's own shadow copy
  logic [7:0] tmem [int];
  logic [7:0] smem [int];

  function automatic logic [7:0] tget(int a);
    return tmem.exists(a) ? tmem[a] : 8'h00;
  endfunction

  function automatic logic [7:0] sget(int a);
    return smem.exists(a) ? smem[a] : 8'h00;
  endfunction

  always @(negedge clk) begin
    int base;
    base = int'({tgt_addr[15:1], 1'b0});
    tgt_rdata <= tgt_re ? {tget(base + 1), tget(base)} : 16'h0000;
  end

  always @(posedge clk) begin
    int base;
    base = int'({tgt_addr[15:1], 1'b0});
    if (tgt_we) begin
      if (tgt_be[0]) tmem[base]     = tgt_wdata[7:0];
      if (tgt_be[1]) tmem[base + 1] = tgt_wdata[15:8];
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Expected region code: 0 none, 1 ctrl, 2 byte-periph, 3 word-periph, 4 RAM, 5 NVM
  function automatic int ref_region(logic [15:0] a);
    if (a < 16'h0010) return 1;
    if (a < 16'h0100) return 2;
    if (a < 16'h0200) return 3;
    if (int'(a) < 'h0200 + RAM_BYTES) return 4;
    if (int'(a) >= NVM_BASE) return 5;
    return 0;
  endfunction

  task automatic txn(logic [15:0] a, logic [15:0] wd, logic byt, logic rd, logic wr,
                     string rtag);
    int          rg;
    logic        act, err, ok;
    logic [1:0]  be;
    logic [4:0]  xsel;
    logic [15:0] xw, xr;
    logic        vh;
    logic [3:0]  vi;
    int          b;
    string       t;

    rg  = ref_region(a);
    act = rd | wr;
    err = act && ((rd && wr) || rg == 0 || (!byt && a[0]) || (!byt && rg == 1) ||
                  (byt && a[0] && rg == 3));
    ok  = act && !err;
    be  = !ok ? 2'b00 : byt ? (a[0] ? 2'b10 : 2'b01) : (rg == 2 ? 2'b01 : 2'b11);
    xsel = ok ? 5'(1 << (rg - 1)) : 5'b0;
    xw  = byt ? {wd[7:0], wd[7:0]} : wd;
    vh  = ok && a >= 16'hFFE0;
    vi  = vh ? a[4:1] : 4'h0;
    b   = int'({a[15:1], 1'b0});
    if (!ok)             xr = 16'h0000;
    else if (byt)        xr = {8'h00, sget(int'(a))};
    else if (rg == 2)    xr = {8'h00, sget(b)};
    else                 xr = {sget(b + 1), sget(b)};

    req_addr = a; req_wdata = wd; req_byte = byt; req_rd = rd; req_wr = wr;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    chk("R2 sel", 32'(sel), 32'(xsel));
    chk("R3 lanes", 32'(tgt_be), 32'(be));
    chk("R4 strobes", {30'b0, tgt_we, tgt_re}, {30'b0, ok && wr, ok && rd});
    if (ok && wr) chk("R4 wdata", 32'(tgt_wdata), 32'(xw));
    if (act) chk("R4 addr", 32'(tgt_addr), 32'(a));
    chk("R5 err", 32'(acc_err), 32'(err));
    chk("R11 vector", {27'b0, vh, vi}, {27'b0, vec_hit, vec_idx});
    if (ok && wr) begin
      if (be[0]) smem[b]     = xw[7:0];
      if (be[1]) smem[b + 1] = xw[15:8];
    end
    @(negedge clk);
    chk("R6 rvalid", 32'(cpu_rvalid), 32'(rd));
    if (rd) begin
      if (rtag != "")          t = rtag;
      else if (err)            t = "R10 err rdata";
      else if (!byt && rg == 2) t = "R7 bper word rdata";
      else if (byt && rg == 3)  t = "R9 wper byte rdata";
      else                     t = "R6 rdata";
      chk(t, 32'(cpu_rdata), 32'(xr));
    end
  endtask

  function automatic logic [15:0] rnd_addr();
    case ($urandom_range(0, 7))
      0: return 16'($urandom_range(0, 'h000F));
      1: return 16'($urandom_range('h0010, 'h00FF));
      2: return 16'($urandom_range('h0100, 'h01FF));
      3: return 16'($urandom_range('h0200, 'h0200 + RAM_BYTES - 1));
      4: return 16'($urandom_range(NVM_BASE, 'hFFFF));
      5: return 16'($urandom_range('hFFE0, 'hFFFF));
      6: return 16'($urandom_range('h0200 + RAM_BYTES, NVM_BASE - 1));
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {sel, tgt_be, tgt_we, tgt_re, acc_err, vec_hit, cpu_rvalid},
        32'h0);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 idle after reset", {cpu_rdata, sel, tgt_be, tgt_we, tgt_re, acc_err, vec_hit},
        32'h0);
    chk("R1 idle data", {tgt_wdata, tgt_addr}, 32'h0);

    // Directed corner cases
    txn(16'h0021, 16'h00AB, 1'b1, 1'b0, 1'b1, "");              // byte write odd, byte-periph
    txn(16'h0020, 16'h1234, 1'b0, 1'b0, 1'b1, "");              // word write, only low lane
    txn(16'h0021, 16'h0000, 1'b1, 1'b1, 1'b0, "R8 odd byte kept");
    txn(16'h0020, 16'h0000, 1'b0, 1'b1, 1'b0, "R7 bper word high zero");
    txn(16'h0100, 16'hBEEF, 1'b0, 1'b0, 1'b1, "");
    txn(16'h0100, 16'h0000, 1'b1, 1'b1, 1'b0, "R9 wper byte high zero");
    txn(16'h0101, 16'h0000, 1'b1, 1'b1, 1'b0, "R10 wper odd byte err");
    txn(16'h0004, 16'h0000, 1'b0, 1'b1, 1'b0, "R10 ctrl word err");
    txn(16'h0005, 16'h0077, 1'b1, 1'b0, 1'b1, "");
    txn(16'h0005, 16'h0000, 1'b1, 1'b1, 1'b0, "R6 ctrl byte read");
    txn(16'h0301, 16'h0000, 1'b0, 1'b1, 1'b0, "R10 odd word err");
    txn(16'h0A00, 16'h0000, 1'b1, 1'b1, 1'b0, "R10 unmapped err");
    txn(16'h0300, 16'h5A5A, 1'b0, 1'b1, 1'b1, "R10 rd+wr err");
    txn(16'hFFFE, 16'hC0DE, 1'b0, 1'b0, 1'b1, "");
    txn(16'hFFFE, 16'h0000, 1'b0, 1'b1, 1'b0, "R11 top vector read");
    txn(16'hFFE0, 16'h0000, 1'b0, 1'b1, 1'b0, "R11 lowest vector read");
    txn(16'hFFDE, 16'h0000, 1'b0, 1'b1, 1'b0, "R11 below window");
    txn(16'h09FF, 16'h00EE, 1'b1, 1'b0, 1'b1, "");
    txn(16'h09FE, 16'h0000, 1'b0, 1'b1, 1'b0, "R6 last RAM word");
    txn(16'hC000, 16'h0000, 1'b0, 1'b1, 1'b0, "R2 first NVM word");
    txn(16'h0040, 16'h0000, 1'b0, 1'b0, 1'b0, "");              // idle request

    // Constrained random traffic
    for (int i = 0; i < 800; i++) begin
      int k;
      logic rd, wr;
      k = $urandom_range(0, 99);
      rd = (k < 45) || (k >= 90 && k < 95);
      wr = (k >= 45 && k < 95);
      txn(rnd_addr(), 16'($urandom), 1'($urandom_range(0, 1)), rd, wr, "");
    end

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

endmodule